// File: doc/BRIEF.md
# Selectable-Ratio Synchronous Clock Divider

This block derives two phase-aligned divided clocks from a single input clock. Output `clk_a` runs at the input rate or at half of it. Output `clk_b` runs at one half, one third, one quarter or one sixth of the input rate. Two mode pins choose the ratio pair. Both dividers count the same qualified rising input edges, so any rising edge the two outputs share happens on the same input edge.

A run enable is captured on the falling input edge, so the internal clock only starts or stops while it is low and no shortened pulse is ever produced. An asynchronous active-low master reset clears every stage and drives both outputs low. Several instances that leave reset together and see the same enable therefore stay in phase. Once reset is released, the first qualified rising edge drives both outputs high.

Top module: `clkdiv_pair`

## Requirements
- R1: While `rst_n` is low, `clk_a` and `clk_b` are low and all divider state is cleared, whatever `clk_in` and `run_en` do; asserting `rst_n` takes effect without a clock edge.
- R2: After `rst_n` rises, the internal enable can only turn on at the third falling `clk_in` edge (release stages = 2, plus the enable capture), and only if `run_en` is high there; both outputs stay low until then. If `run_en` is low, nothing starts until a later falling edge sees it high.
- R3: The first rising `clk_in` edge after the internal enable turns on drives both outputs high.
- R4: With `mode_fast`=0 and `mode_alt`=0, `clk_a` is the input divided by 2 and `clk_b` the input divided by 4.
- R5: With `mode_fast`=0 and `mode_alt`=1, `clk_a` divides by 2 and `clk_b` divides by 6.
- R6: With `mode_fast`=1 and `mode_alt`=0, `clk_a` is the gated input clock (high for the high half of every enabled input cycle) and `clk_b` divides by 2.
- R7: With `mode_fast`=1 and `mode_alt`=1, `clk_a` is the gated input clock and `clk_b` divides by 3: high for one input cycle, then low for two.
- R8: The divide-by-2, divide-by-4 and divide-by-6 outputs are high for exactly half of their period.
- R9: `run_en` is sampled only on falling `clk_in` edges. While the sampled enable is low, both outputs hold their levels (`clk_a` in pass-through mode holds low). When the enable returns, counting resumes from the same phase.
- R10: With `mode_fast`=0, every rising edge of `clk_b` coincides with a rising edge of `clk_a`.
- R11: A change of `mode_alt` while running leaves the `clk_b` period in progress unchanged. The new ratio takes effect from the next period start of `clk_b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low master reset |
| run_en | input | 1 | Run enable, sampled on falling `clk_in` edges |
| mode_fast | input | 1 | 1: `clk_a` passes the gated clock and `clk_b` divides by 2/3; 0: `clk_a` divides by 2 and `clk_b` by 4/6 |
| mode_alt | input | 1 | Picks the larger `clk_b` ratio of the pair (3 or 6) when high |
| clk_a | output | 1 | Divide-by-1 or divide-by-2 output |
| clk_b | output | 1 | Divide-by-2, 3, 4 or 6 output |

## Verification
Divided outputs change right after the rising `clk_in` edge of each qualified cycle. In pass-through mode, `clk_a` also falls with the falling edge. A change of `run_en` counts from the next falling edge, and a fresh release of `rst_n` produces its first output rise at the rising edge after the third falling edge. The bench keeps a model of the enable pipeline and both divider phases, advanced on every `clk_in` edge. It samples the outputs 1 ns after each edge and changes inputs 1.2 ns after an edge. Each expectation is therefore compared in the half cycle that the edge just produced.

// File: rtl/cd_pkg.sv
package cd_pkg;

  // Ratios of the two outputs for each mode-pin combination
  localparam int unsigned RATIO_A_SLOW    = 2;
  localparam int unsigned RATIO_B_SLOW_LO = 4;
  localparam int unsigned RATIO_B_SLOW_HI = 6;
  localparam int unsigned RATIO_B_FAST_LO = 2;
  localparam int unsigned RATIO_B_FAST_HI = 3;
  localparam int unsigned RATIO_MAX       = 6;

  localparam int unsigned CNT_W = $clog2(RATIO_MAX + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  // Ratio of output B selected by the mode pins
  function automatic cnt_t b_ratio(input logic fast, input logic alt);
    cnt_t r;
    case ({fast, alt})
      2'b00:   r = cnt_t'(RATIO_B_SLOW_LO);
      2'b01:   r = cnt_t'(RATIO_B_SLOW_HI);
      2'b10:   r = cnt_t'(RATIO_B_FAST_LO);
      default: r = cnt_t'(RATIO_B_FAST_HI);
    endcase
    return r;
  endfunction

  // Number of counts the output stays high: half for even ratios, one for odd
  function automatic cnt_t high_len(input cnt_t n);
    return n[0] ? cnt_t'(1) : (n >> 1);
  endfunction

endpackage

// File: rtl/cd_enable_gate.sv
module cd_enable_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic run_en,
  output logic gate_en,
  output logic gck
);

  logic [SYNC_STAGES-1:0] rel_q;
  logic [SYNC_STAGES-1:0] rel_d;
  logic                   en_q;
  logic                   en_d;

  // Reset release walks through a falling-edge shift chain before enabling
  always_comb begin
    rel_d = (rel_q << 1) | {{(SYNC_STAGES-1){1'b0}}, 1'b1};
    en_d  = run_en & rel_q[SYNC_STAGES-1];
  end

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= '0;
      en_q  <= 1'b0;
    end else begin
      rel_q <= rel_d;
      en_q  <= en_d;
    end
  end

  assign gate_en = en_q;
  // en_q only moves while clk_in is low, so this AND cannot form a runt
  assign gck     = clk_in & en_q;

endmodule

// File: rtl/cd_ratio_div.sv
module cd_ratio_div
  import cd_pkg::*;
(
  input  logic clk_in,
  input  logic rst_n,
  input  logic tick,
  input  cnt_t ratio_live,
  input  cnt_t ratio_held,
  output logic at_start,
  output logic div_out
);

  cnt_t cnt_q;
  cnt_t cnt_d;
  cnt_t len;
  logic out_q;
  logic out_d;

  assign at_start = (cnt_q == '0);

  // Period start uses the live ratio; later counts use the held one
  always_comb begin
    len   = at_start ? ratio_live : ratio_held;
    cnt_d = cnt_q;
    out_d = out_q;
    if (tick) begin
      out_d = (cnt_q < high_len(len));
      cnt_d = (cnt_q == len - cnt_t'(1)) ? '0 : cnt_q + cnt_t'(1);
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign div_out = out_q;

endmodule

// File: rtl/clkdiv_pair.sv
module clkdiv_pair
  import cd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic run_en,
  input  logic mode_fast,
  input  logic mode_alt,
  output logic clk_a,
  output logic clk_b
);

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_A   = 0;
  localparam int unsigned CH_B   = 1;

  logic              gate_en;
  logic              gck;
  cnt_t              ratio_live [NUM_CH];
  cnt_t              ratio_q    [NUM_CH];
  cnt_t              ratio_d    [NUM_CH];
  logic [NUM_CH-1:0] at_start;
  logic [NUM_CH-1:0] div_out;
  logic              a_mode_q;
  logic              a_mode_d;

  cd_enable_gate #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_gate (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .gate_en (gate_en),
    .gck     (gck)
  );

  assign ratio_live[CH_A] = cnt_t'(RATIO_A_SLOW);
  assign ratio_live[CH_B] = b_ratio(mode_fast, mode_alt);

  // Ratios and the pass-through choice are captured at a period start
  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      ratio_d[ch] = (gate_en && at_start[ch]) ? ratio_live[ch] : ratio_q[ch];
    end
    a_mode_d = (gate_en && at_start[CH_A]) ? mode_fast : a_mode_q;
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        ratio_q[ch] <= '0;
      end
      a_mode_q <= 1'b0;
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        ratio_q[ch] <= ratio_d[ch];
      end
      a_mode_q <= a_mode_d;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    cd_ratio_div u_div (
      .clk_in     (clk_in),
      .rst_n      (rst_n),
      .tick       (gate_en),
      .ratio_live (ratio_live[ch]),
      .ratio_held (ratio_q[ch]),
      .at_start   (at_start[ch]),
      .div_out    (div_out[ch])
    );
  end

  assign clk_a = a_mode_q ? gck : div_out[CH_A];
  assign clk_b = div_out[CH_B];

endmodule

// File: rtl/cd_checker.sv
module cd_checker
  import cd_pkg::*;
(
  input logic clk_in,
  input logic rst_n,
  input logic gate_en,
  input logic clk_a,
  input logic clk_b,
  input logic a_div,
  input logic b_div,
  input logic a_mode,
  input cnt_t b_ratio
);

  always @(negedge clk_in) begin
    if (rst_n === 1'b0) begin
      AST_RESET_CLEAR: assert (clk_a === 1'b0 && clk_b === 1'b0); // R1
    end
  end

  always @(gate_en) begin
    if (rst_n === 1'b1) begin
      AST_GATE_CLK_LOW: assert (clk_in === 1'b0); // R9
    end
  end

  AST_HOLD_STILL: assert property (@(posedge clk_in) disable iff (!rst_n)
    !gate_en |=> ($stable(b_div) && $stable(a_div))); // R9

  AST_ALIGN_RISE: assert property (@(posedge clk_in) disable iff (!rst_n)
    ($rose(b_div) && !a_mode) |-> $rose(a_div)); // R10

  AST_THIRD_SHORT: assert property (@(posedge clk_in) disable iff (!rst_n)
    ($rose(b_div) && b_ratio == cnt_t'(3) && gate_en) |=> !b_div); // R7

endmodule

bind clkdiv_pair cd_checker u_chk (
  .clk_in  (clk_in),
  .rst_n   (rst_n),
  .gate_en (gate_en),
  .clk_a   (clk_a),
  .clk_b   (clk_b),
  .a_div   (div_out[0]),
  .b_div   (div_out[1]),
  .a_mode  (a_mode_q),
  .b_ratio (ratio_q[1])
);

// File: tb/sim_clkdiv_pair.sv
`timescale 1ns/1ps
module sim_clkdiv_pair;

  localparam int SYNC = 2;

  logic clk;
  logic rst_n;
  logic run_en;
  logic mode_fast;
  logic mode_alt;
  logic clk_a;
  logic clk_b;

  clkdiv_pair #(.SYNC_STAGES(SYNC)) u0 (
    .clk_in    (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .mode_fast (mode_fast),
    .mode_alt  (mode_alt),
    .clk_a     (clk_a),
    .clk_b     (clk_b)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic  a;
    logic  b;
    string req;
  } exp_t;

  exp_t  q[$];
  int    checks;
  int    fails;
  bit    done;
  string cur_req;

  // Reference model state
  int rel_cnt;
  bit en_m;
  int a_pos, a_n, b_pos, b_n;
  bit a_o, b_o, a_mode_m;

  function automatic void model_reset();
    rel_cnt = 0; en_m = 0;
    a_pos = 0; a_n = 0; b_pos = 0; b_n = 0;
    a_o = 0; b_o = 0; a_mode_m = 0;
  endfunction

  function automatic int live_b();
    if (mode_fast) return mode_alt ? 3 : 2;
    return mode_alt ? 6 : 4;
  endfunction

  function automatic void step_div(ref int pos, ref int n, ref bit o, input int live);
    int len;
    len = (pos == 0) ? live : n;
    if (pos == 0) n = live;
    o   = (pos < (((len % 2) == 1) ? 1 : len / 2));
    pos = (pos + 1 == len) ? 0 : pos + 1;
  endfunction

  // Driver: advance the model one clock edge and queue the expected outputs
  task automatic half();
    exp_t e;
    bit   gck;
    @(posedge clk or negedge clk);
    if (!rst_n) begin
      model_reset();
    end else if (clk) begin
      if (en_m) begin
        if (a_pos == 0) a_mode_m = mode_fast;
        step_div(a_pos, a_n, a_o, 2);
        step_div(b_pos, b_n, b_o, live_b());
      end
    end else begin
      en_m = run_en && (rel_cnt >= SYNC);
      rel_cnt++;
    end
    gck   = clk && en_m;
    e.a   = a_mode_m ? gck : a_o;
    e.b   = b_o;
    e.req = cur_req;
    q.push_back(e);
    #1.2;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) half();
  endtask

  task automatic do_case(input bit f, input bit al, input string tag, input int n);
    rst_n = 1'b0;
    model_reset();
    mode_fast = f;
    mode_alt  = al;
    run_en    = 1'b1;
    cur_req   = "R1";
    run(4);
    rst_n   = 1'b1;
    cur_req = "R2/R3";
    run(8);
    cur_req = tag;
    run(n);
  endtask

  // Monitor: compare the queued expectations 1 ns after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk or negedge clk);
      #1;
      while (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (clk_a !== e.a || clk_b !== e.b) begin
          fails++;
          $display("FAIL %s: clk_a=%b clk_b=%b expected clk_a=%b clk_b=%b at %0t",
                   e.req, clk_a, clk_b, e.a, e.b, $time);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=still running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; run_en = 1'b0; mode_fast = 1'b0; mode_alt = 1'b0;
    cur_req = "R1";
    model_reset();
    run(6);
    run_en = 1'b1;                 // R1: enable toggling has no effect in reset
    run(6);

    do_case(1'b0, 1'b0, "R4/R8/R10", 48);
    cur_req = "R9";
    run_en = 1'b0;
    run(10);
    run_en = 1'b1;
    run(24);
    cur_req = "R1";                // asynchronous reset in the middle of a run
    rst_n = 1'b0;
    model_reset();
    run(4);

    do_case(1'b0, 1'b1, "R5/R8/R10", 60);
    do_case(1'b1, 1'b0, "R6", 40);
    cur_req = "R9";
    run_en = 1'b0;
    run(9);
    run_en = 1'b1;
    run(16);
    do_case(1'b1, 1'b1, "R7", 48);

    // R2: enable held low across the reset release
    rst_n = 1'b0; model_reset(); run_en = 1'b0;
    mode_fast = 1'b0; mode_alt = 1'b0;
    cur_req = "R1";
    run(4);
    rst_n = 1'b1;
    cur_req = "R2";
    run(14);
    run_en = 1'b1;
    run(20);

    // R11: ratio change while running, in the middle of a clk_b period
    do_case(1'b0, 1'b0, "R4", 21);
    mode_alt = 1'b1;
    cur_req = "R11";
    run(60);
    mode_alt = 1'b0;
    run(40);

    done = 1;
    #3;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule